// File: doc/BRIEF.md
# Guarded Halfword Load Unit

This block is the load path for an unsigned 16-bit read in a processor that predicates every operation on a guard register. For each accepted load it reads two neighbouring bytes from a byte-addressed data memory. It places them in a halfword according to a byte-order bit supplied with the load, extends the halfword with zeros to the register width, and presents a register write-back a fixed three cycles after issue.

Only bit 0 of the guard operand matters. When that bit is clear the load does nothing: it does not read memory, does not write back and signals no cache-status update. Misaligned addresses and addresses inside a parameterised memory-mapped I/O window are not trapped. Such loads still complete and write back, but their data is undefined, and the write-back carries a flag for each case so that later logic and test benches can treat the data as don't-care.

The pipeline has three register stages, and each stage carries its own valid bit, destination index, byte order and flags. A new load can be accepted every cycle. The block has no state machine: the byte-order bit and the stage valid bits are its only control state.

Top module: `hload_unit`

## Requirements
- R1: With `iss_little` = 1, `wb_data[7:0]` holds the byte at the issue address and `wb_data[15:8]` holds the byte at address+1.
- R2: With `iss_little` = 0, `wb_data[15:8]` holds the byte at the issue address and `wb_data[7:0]` holds the byte at address+1. For example, bytes 0x22 then 0x11 give 0x00002211.
- R3: `wb_data[31:16]` is zero on every write-back.
- R4: Only `iss_guard[0]` is used. When it is 0, the load raises neither `mem_rd_en` nor, later, `wb_en` or `wb_cache_touch`. When it is 1, both happen. The other guard bits have no effect.
- R5: A load issued with the guard set in cycle t raises `wb_en` in cycle t+3, with `wb_dst` equal to the issued destination index.
- R6: Loads issued on consecutive cycles each write back, in issue order and on consecutive cycles.
- R7: On a write-back, `wb_misaligned` equals bit 0 of the load's address. A misaligned load still writes back and raises no other signal.
- R8: On a write-back, `wb_mmio_hit` is 1 exactly when the address lies in [MMIO_BASE, MMIO_BASE+MMIO_SIZE). `wb_cache_touch` is 1 only for write-backs that are outside that window.
- R9: A synchronous active-high `rst` empties every stage. No write-back follows a reset, including for loads that were in flight when it arrived.
- R10: In the issue cycle, `mem_rd_en` is driven and `mem_rd_addr` equals `iss_addr`. Lane 0 returns the byte at that address and lane 1 returns the byte at address+1, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | A load is presented this cycle |
| iss_addr | input | 32 | Byte address of the halfword |
| iss_guard | input | 32 | Guard operand; bit 0 enables the load |
| iss_little | input | 1 | 1 = little-endian, 0 = big-endian |
| iss_dst | input | 5 | Destination register index |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rd_lane0 | input | 8 | Byte at read address, valid one cycle later |
| mem_rd_lane1 | input | 8 | Byte at read address+1, valid one cycle later |
| wb_en | output | 1 | Register write enable |
| wb_dst | output | 5 | Register index written |
| wb_data | output | 32 | Zero-extended halfword |
| wb_cache_touch | output | 1 | Cache-status update for this write-back |
| wb_misaligned | output | 1 | Address was odd; data is undefined |
| wb_mmio_hit | output | 1 | Address was in the I/O window; data is undefined |

## Verification
The same bytes are loaded in both byte orders. Swapped halves in the result separate the two orderings, and the nonzero upper byte values show that the zero extension is really applied. Guard operands with bit 0 clear but upper bits set, and guard operands with bit 0 set alongside other bits, show that only bit 0 decides. Loads are issued back to back so that any mismatch in stage alignment shows up as a wrong destination or wrong data. An odd address, an address inside the I/O window, and a reset arriving while a load is in flight cover the flag and flush behaviour.

// File: rtl/hload_pkg.sv
package hload_pkg;
    localparam int ADDR_W = 32;
    localparam int REG_W  = 32;
    localparam int IDX_W  = 5;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 2 * BYTE_W;
    localparam int LAT    = 3;

    typedef enum logic {
        ORD_BIG    = 1'b0,
        ORD_LITTLE = 1'b1
    } byte_order_e;

    typedef struct packed {
        logic               vld;
        logic [IDX_W-1:0]   dst;
        byte_order_e        order;
        logic               misal;
        logic               mmio;
        logic [HALF_W-1:0]  half;
    } stage_t;
endpackage

// File: rtl/hload_issue.sv
module hload_issue
    import hload_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MMIO_BASE = 32'hEFE0_0000,
    parameter logic [ADDR_W-1:0] MMIO_SIZE = 32'h0020_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic [REG_W-1:0]  iss_guard,
    input  logic              iss_little,
    input  logic [IDX_W-1:0]  iss_dst,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output stage_t            nxt
);
    logic              fire;
    logic [ADDR_W-1:0] win_off;

    always_comb begin
        fire        = iss_valid & iss_guard[0];
        win_off     = iss_addr - MMIO_BASE;
        mem_rd_en   = fire;
        mem_rd_addr = iss_addr;
        nxt.vld     = fire;
        nxt.dst     = iss_dst;
        nxt.order   = byte_order_e'(iss_little);
        nxt.misal   = iss_addr[0];
        nxt.mmio    = (win_off < MMIO_SIZE);
        nxt.half    = '0;
    end

    // R4
    guard_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_guard[0]) |-> !mem_rd_en);
endmodule

// File: rtl/hload_lane_sort.sv
module hload_lane_sort
    import hload_pkg::*;
(
    input  byte_order_e        order,
    input  logic [BYTE_W-1:0]  lane_lo_addr,
    input  logic [BYTE_W-1:0]  lane_hi_addr,
    output logic [HALF_W-1:0]  half
);
    always_comb begin
        unique case (order)
            ORD_LITTLE: half = {lane_hi_addr, lane_lo_addr};
            ORD_BIG:    half = {lane_lo_addr, lane_hi_addr};
            default:    half = '0;
        endcase
    end
endmodule

// File: rtl/hload_stage.sv
module hload_stage
    import hload_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  stage_t d,
    output stage_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/hload_unit.sv
module hload_unit
    import hload_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MMIO_BASE = 32'hEFE0_0000,
    parameter logic [ADDR_W-1:0] MMIO_SIZE = 32'h0020_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic [REG_W-1:0]  iss_guard,
    input  logic              iss_little,
    input  logic [IDX_W-1:0]  iss_dst,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [BYTE_W-1:0] mem_rd_lane0,
    input  logic [BYTE_W-1:0] mem_rd_lane1,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_dst,
    output logic [REG_W-1:0]  wb_data,
    output logic              wb_cache_touch,
    output logic              wb_misaligned,
    output logic              wb_mmio_hit
);
    localparam int EXT_W = REG_W - HALF_W;

    stage_t st_d [LAT];
    stage_t st_q [LAT];
    stage_t issue_bus;
    logic [HALF_W-1:0] sorted;

    hload_issue #(.MMIO_BASE(MMIO_BASE), .MMIO_SIZE(MMIO_SIZE)) u_issue (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_addr(iss_addr),
        .iss_guard(iss_guard), .iss_little(iss_little), .iss_dst(iss_dst),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .nxt(issue_bus)
    );

    // memory lanes are valid while the load sits in the first stage
    hload_lane_sort u_sort (
        .order(st_q[0].order), .lane_lo_addr(mem_rd_lane0),
        .lane_hi_addr(mem_rd_lane1), .half(sorted)
    );

    for (genvar s = 0; s < LAT; s++) begin : g_stage
        if (s == 0) begin : g_head
            assign st_d[s] = issue_bus;
        end else if (s == 1) begin : g_fill
            always_comb begin
                st_d[s]      = st_q[s-1];
                st_d[s].half = sorted;
            end
        end else begin : g_carry
            assign st_d[s] = st_q[s-1];
        end
        hload_stage u_stage (.clk(clk), .rst(rst), .d(st_d[s]), .q(st_q[s]));
    end

    always_comb begin
        wb_en          = st_q[LAT-1].vld;
        wb_dst         = st_q[LAT-1].dst;
        wb_data        = {{EXT_W{1'b0}}, st_q[LAT-1].half};
        wb_cache_touch = st_q[LAT-1].vld & ~st_q[LAT-1].mmio;
        wb_misaligned  = st_q[LAT-1].misal;
        wb_mmio_hit    = st_q[LAT-1].mmio;
    end

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_guard[0]) |=> ##2 (wb_en && wb_dst == $past(iss_dst, 3)));
    // R3
    zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_data[REG_W-1:HALF_W] == '0));
    // R8
    cache_touch_chk: assert property (@(posedge clk) disable iff (rst)
        wb_cache_touch |-> (wb_en && !wb_mmio_hit));
    // R9
    reset_flush_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !wb_en);
endmodule

// File: tb/test_hload_unit.sv
module test_hload_unit;
    localparam logic [31:0] WIN_BASE = 32'h0000_0800;
    localparam logic [31:0] WIN_SIZE = 32'h0000_0100;
    localparam int NV = 10;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] guard;
        logic        little;
        logic [4:0]  dst;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{32'h0000_0d00, 32'h0000_0001, 1'b0, 5'd6},
        '{32'h0000_0d04, 32'h0000_0000, 1'b0, 5'd7},
        '{32'h0000_0d04, 32'h0000_0001, 1'b0, 5'd8},
        '{32'h0000_0d00, 32'h0000_0001, 1'b1, 5'd9},
        '{32'h0000_0d04, 32'hFFFF_FFFE, 1'b1, 5'd10},
        '{32'h0000_0d04, 32'h0000_0003, 1'b1, 5'd11},
        '{32'h0000_0d01, 32'h0000_0001, 1'b0, 5'd12},
        '{32'h0000_0810, 32'h0000_0001, 1'b1, 5'd13},
        '{32'h0000_0100, 32'h0000_0005, 1'b0, 5'd31},
        '{32'h0000_02fe, 32'h8000_0001, 1'b1, 5'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0;
    logic [31:0] iss_addr = '0;
    logic [31:0] iss_guard = '0;
    logic        iss_little = 1'b0;
    logic [4:0]  iss_dst = '0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [7:0]  mem_rd_lane0 = '0;
    logic [7:0]  mem_rd_lane1 = '0;
    logic        wb_en, wb_cache_touch, wb_misaligned, wb_mmio_hit;
    logic [4:0]  wb_dst;
    logic [31:0] wb_data;

    logic [7:0] mem [4096];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hload_unit #(.MMIO_BASE(WIN_BASE), .MMIO_SIZE(WIN_SIZE)) i_hload_unit (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_addr(iss_addr),
        .iss_guard(iss_guard), .iss_little(iss_little), .iss_dst(iss_dst),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_lane0(mem_rd_lane0), .mem_rd_lane1(mem_rd_lane1),
        .wb_en(wb_en), .wb_dst(wb_dst), .wb_data(wb_data),
        .wb_cache_touch(wb_cache_touch), .wb_misaligned(wb_misaligned),
        .wb_mmio_hit(wb_mmio_hit)
    );

    // byte memory model: lanes valid one cycle after the read strobe (R10)
    always_ff @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_lane0 <= mem[mem_rd_addr[11:0]];
            mem_rd_lane1 <= mem[mem_rd_addr[11:0] + 12'd1];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_wb(input vec_t v, input int n);
        logic [7:0]  b0, b1;
        logic [31:0] exp;
        bit          win;
        b0  = mem[v.addr[11:0]];
        b1  = mem[v.addr[11:0] + 12'd1];
        exp = v.little ? {16'h0, b1, b0} : {16'h0, b0, b1};
        win = (v.addr >= WIN_BASE) && (v.addr < WIN_BASE + WIN_SIZE);
        chk(wb_en == v.guard[0], "R4/R5/R6", $sformatf("wb_en vec%0d", n),
            32'(wb_en), 32'(v.guard[0]));
        if (v.guard[0]) begin
            chk(wb_dst == v.dst, "R5/R6", $sformatf("wb_dst vec%0d", n),
                32'(wb_dst), 32'(v.dst));
            chk(wb_misaligned == v.addr[0], "R7", $sformatf("misaligned vec%0d", n),
                32'(wb_misaligned), 32'(v.addr[0]));
            chk(wb_mmio_hit == win, "R8", $sformatf("mmio vec%0d", n),
                32'(wb_mmio_hit), 32'(win));
            chk(wb_cache_touch == !win, "R8", $sformatf("cache touch vec%0d", n),
                32'(wb_cache_touch), 32'(!win));
            chk(wb_data[31:16] == 16'h0, "R3", $sformatf("upper half vec%0d", n),
                wb_data, exp);
            if (!v.addr[0] && !win)
                chk(wb_data == exp, v.little ? "R1" : "R2",
                    $sformatf("data vec%0d", n), wb_data, exp);
        end else begin
            chk(wb_cache_touch == 1'b0, "R4", $sformatf("no side effect vec%0d", n),
                32'(wb_cache_touch), 32'h0);
        end
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37 + 11);
        mem[12'hd00] = 8'h22; mem[12'hd01] = 8'h11;
        mem[12'hd04] = 8'h84; mem[12'hd05] = 8'h33;

        repeat (3) @(negedge clk);
        chk(wb_en == 1'b0, "R9", "wb_en in reset", 32'(wb_en), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(wb_en == 1'b0 && wb_cache_touch == 1'b0, "R9", "idle after reset",
            32'(wb_en), 32'h0);

        // back-to-back table walk (R6); write-back sampled three cycles on
        for (int n = 0; n < NV + 3; n++) begin
            if (n >= 3) check_wb(TBL[n-3], n - 3);
            if (n < NV) begin
                iss_valid  = 1'b1;
                iss_addr   = TBL[n].addr;
                iss_guard  = TBL[n].guard;
                iss_little = TBL[n].little;
                iss_dst    = TBL[n].dst;
                #1;
                chk(mem_rd_en == TBL[n].guard[0], "R10/R4", $sformatf("rd strobe vec%0d", n),
                    32'(mem_rd_en), 32'(TBL[n].guard[0]));
                if (TBL[n].guard[0])
                    chk(mem_rd_addr == TBL[n].addr, "R10", $sformatf("rd addr vec%0d", n),
                        mem_rd_addr, TBL[n].addr);
            end else begin
                iss_valid = 1'b0;
            end
            @(negedge clk);
        end

        // worked big-endian case, explicit (R2, R3)
        iss_valid = 1'b1; iss_addr = 32'h0d04; iss_guard = 32'h1;
        iss_little = 1'b0; iss_dst = 5'd20;
        @(negedge clk);
        iss_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(wb_en && wb_data == 32'h0000_8433, "R2", "worked case 0xd04",
            wb_data, 32'h0000_8433);

        // reset while a load is in flight (R9)
        iss_valid = 1'b1; iss_addr = 32'h0d00; iss_guard = 32'h1; iss_dst = 5'd3;
        @(negedge clk);
        iss_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(wb_en == 1'b0, "R9", $sformatf("flushed load cycle %0d", k),
                32'(wb_en), 32'h0);
            @(negedge clk);
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=hung expected=finished");
            end
            wait (done);
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule